// File: doc/BRIEF.md
# Streaming 8-Point DCT Engine

This block takes a stream of signed 8-bit samples, one per clock when `in_valid` is high, and treats each run of eight accepted samples as one row. For every row it produces the eight coefficients of a one-dimensional discrete cosine transform. The coefficients leave the block as a burst of eight consecutive valid cycles, each tagged with its coefficient index. No hardware multipliers are used. A butterfly stage folds the row into four mirrored sums and four mirrored differences. A single bit-parallel distributed-arithmetic engine then evaluates one coefficient per clock. It uses a table of precomputed partial sums of 12-bit cosine constants and adds the shifted lookups together. The sign-bit slice is subtracted, so signed operands need no special handling.

Because the engine is shared over the eight clocks that the next row needs to arrive, rows can follow each other with no gap, and the block never stalls its input. Each result is rounded to nearest and then clamped to the output width. It is meant as the row or column stage of a larger two-dimensional transform.

Top module: `dct8_stream`

## Requirements
- R1: A synchronous active-high `rst` clears the block: `out_valid` is low in every cycle after a reset edge until a new row completes, and any samples accepted before the reset are discarded, so the next eight accepted samples form a fresh row.
- R2: Samples are accepted only on cycles with `in_valid` high, in order x[0]..x[7]. Idle cycles between samples, or between rows, do not change the result.
- R3: Every complete row yields exactly eight output cycles with `out_valid` high, on consecutive clocks, with `out_idx` stepping 0,1,...,7. No output appears without a completed row.
- R4: Coefficient 0 of a row is presented two clock edges after the edge that accepts that row's eighth sample. Back-to-back rows give back-to-back bursts with no stall.
- R5: `out_data` for index k equals floor((A + 1024) / 2048), where A = sum over n of x[n]*C(k,n). Here C(k,n) = round(1024*cos((2n+1)k*pi/16)) for k >= 1, and C(0,n) = round(1024/sqrt(2)) = 724. Samples are two's complement.
- R6: Even-index outputs depend only on the mirrored sums x[n]+x[7-n], and odd-index outputs only on the mirrored differences. A mirror-symmetric row gives zero at every odd index, and a mirror-antisymmetric row gives zero at every even index.
- R7: Full-scale signed rows, including all -128, all +127 and alternating extremes, follow R5 exactly. An all -128 row gives -362 at index 0.
- R8: A result outside the range of an OUT_W-bit signed number is clamped to -(2^(OUT_W-1)) or 2^(OUT_W-1)-1 and does not wrap. With OUT_W = 8, an all +127 row gives 127 at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample qualifier |
| in_data | input | IN_W (8) | Signed input sample |
| out_valid | output | 1 | Coefficient qualifier |
| out_idx | output | 3 | Coefficient index 0..7 of the current output |
| out_data | output | OUT_W (11) | Signed, rounded and clamped coefficient |

## Verification
A corrupted partial-sum table entry or a wrong butterfly term shows up as a wrong value at particular coefficient indices. It is visible two cycles after the row's last sample and only for rows whose bit patterns address that entry. For that reason impulses at every position, full-scale rows and a long run of pseudo-random rows are applied. A broken row counter or sequencer shows up at once as a misplaced index, a burst that starts at the wrong cycle, or a row built from the wrong samples. A second instance with a narrow output makes clamping visible at the ports.

// File: rtl/dct8_pkg.sv
package dct8_pkg;
  localparam int N         = 8;
  localparam int HALF      = N / 2;
  localparam int IDX_W     = $clog2(N);
  localparam int COEF_W    = 12;
  localparam int COEF_FRAC = 11;
  localparam int LUT_W     = COEF_W + 2;
  localparam int ROM_D     = 1 << HALF;

  // round(2^(COEF_FRAC-1) * cos(m*pi/16)) for m = 0..8
  function automatic int cos_q(input int m);
    case (m)
      0: return 1024;
      1: return 1004;
      2: return 946;
      3: return 851;
      4: return 724;
      5: return 569;
      6: return 392;
      7: return 200;
      default: return 0;
    endcase
  endfunction

  // Weight of folded pair i in coefficient k
  function automatic int basis(input int k, input int i);
    int a;
    if (k == 0) return cos_q(4);
    a = ((2 * i + 1) * k) % (4 * N);
    if (a > 2 * N) a = 4 * N - a;
    if (a <= N) return cos_q(a);
    return -cos_q(2 * N - a);
  endfunction

  // Partial sum selected by one bit slice of the four folded operands
  function automatic int lut_sum(input int k, input int sel);
    int s;
    s = 0;
    for (int i = 0; i < HALF; i++)
      if (((sel >> i) & 1) == 1) s = s + basis(k, i);
    return s;
  endfunction
endpackage

// File: rtl/dct8_gather.sv
module dct8_gather
  import dct8_pkg::*;
#(
  parameter int IN_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic signed [IN_W-1:0] in_data,
  output logic                   row_valid,
  output logic signed [IN_W:0]   sum_o [HALF],
  output logic signed [IN_W:0]   dif_o [HALF]
);
  logic [IDX_W-1:0]       pos_q;
  logic signed [IN_W-1:0] hold_q [N-1];
  logic signed [IN_W-1:0] row_w  [N];
  logic                   last;

  for (genvar n = 0; n < N - 1; n++) begin : g_row
    assign row_w[n] = hold_q[n];
  end
  assign row_w[N-1] = in_data;

  assign last = in_valid && (pos_q == IDX_W'(N - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q     <= '0;
      row_valid <= 1'b0;
    end else begin
      row_valid <= last;
      if (in_valid) pos_q <= last ? '0 : pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && !last) hold_q[pos_q] <= in_data;
  end

  // Butterfly: mirrored sums feed even outputs, differences feed odd ones
  always_ff @(posedge clk) begin
    if (last) begin
      for (int i = 0; i < HALF; i++) begin
        sum_o[i] <= (IN_W+1)'(row_w[i]) + (IN_W+1)'(row_w[N-1-i]);
        dif_o[i] <= (IN_W+1)'(row_w[i]) - (IN_W+1)'(row_w[N-1-i]);
      end
    end
  end

  AST_ROW_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    row_valid |-> $past(in_valid)); // R2
endmodule

// File: rtl/dct8_da.sv
module dct8_da
  import dct8_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int ACC_W = IN_W + 1 + LUT_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [IDX_W-1:0]        k_i,
  input  logic signed [IN_W:0]    sum_i [HALF],
  input  logic signed [IN_W:0]    dif_i [HALF],
  output logic                    acc_valid,
  output logic [IDX_W-1:0]        acc_k,
  output logic signed [ACC_W-1:0] acc_o
);
  localparam int VAL_W = IN_W + 1;
  localparam int ROM_N = N * ROM_D;

  logic signed [LUT_W-1:0] rom  [ROM_N];
  logic signed [VAL_W-1:0] vec  [HALF];
  logic [HALF-1:0]         sel  [VAL_W];
  logic signed [LUT_W-1:0] part [VAL_W];
  logic signed [ACC_W-1:0] acc_w;
  logic                    vec_zero;

  // Partial-sum table: entry {k, sel} = sum of basis weights picked by sel
  for (genvar g = 0; g < ROM_N; g++) begin : g_rom
    assign rom[g] = LUT_W'(lut_sum(g / ROM_D, g % ROM_D));
  end

  always_comb begin
    vec_zero = 1'b1;
    for (int i = 0; i < HALF; i++) begin
      vec[i] = k_i[0] ? dif_i[i] : sum_i[i];
      if (vec[i] != '0) vec_zero = 1'b0;
    end
  end

  for (genvar b = 0; b < VAL_W; b++) begin : g_slice
    for (genvar i = 0; i < HALF; i++) begin : g_bit
      assign sel[b][i] = vec[i][b];
    end
    assign part[b] = rom[{k_i, sel[b]}];
  end

  // Shift-add over all bit slices; the sign slice carries negative weight
  always_comb begin
    acc_w = '0;
    for (int b = 0; b < VAL_W; b++) begin
      if (b == VAL_W - 1) acc_w = acc_w - (ACC_W'(part[b]) <<< b);
      else                acc_w = acc_w + (ACC_W'(part[b]) <<< b);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) acc_valid <= 1'b0;
    else     acc_valid <= in_valid;
    acc_k <= k_i;
    acc_o <= acc_w;
  end

  AST_ZERO_OPERANDS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && vec_zero) |=> (acc_o == '0)); // R6
  AST_STAGE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (acc_valid && acc_k == $past(k_i))); // R3
endmodule

// File: rtl/dct8_round_sat.sv
module dct8_round_sat
  import dct8_pkg::*;
#(
  parameter int ACC_W = 23,
  parameter int OUT_W = 11,
  parameter int FRAC  = COEF_FRAC
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [IDX_W-1:0]        k_i,
  input  logic signed [ACC_W-1:0] acc_i,
  output logic                    out_valid,
  output logic [IDX_W-1:0]        out_idx,
  output logic signed [OUT_W-1:0] out_data
);
  localparam int RND_W    = ACC_W + 1 - FRAC;
  localparam int HALF_LSB = 1 << (FRAC - 1);
  localparam int MAXV     = (1 << (OUT_W - 1)) - 1;
  localparam int MINV     = -(1 << (OUT_W - 1));
  localparam logic signed [RND_W-1:0] MAXV_R = RND_W'(MAXV);
  localparam logic signed [RND_W-1:0] MINV_R = RND_W'(MINV);

  logic signed [ACC_W:0]   biased;
  logic signed [RND_W-1:0] rnd;

  assign biased = {acc_i[ACC_W-1], acc_i} + (ACC_W+1)'(HALF_LSB);
  assign rnd    = biased[ACC_W:FRAC];

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
    out_idx <= k_i;
    if (rnd > MAXV_R)      out_data <= OUT_W'(MAXV);
    else if (rnd < MINV_R) out_data <= OUT_W'(MINV);
    else                   out_data <= OUT_W'(rnd);
  end

  AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rnd > MAXV_R) |=> (out_data == OUT_W'(MAXV))); // R8
  AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rnd < MINV_R) |=> (out_data == OUT_W'(MINV))); // R8
endmodule

// File: rtl/dct8_stream.sv
module dct8_stream
  import dct8_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int OUT_W = 11
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic [IDX_W-1:0]        out_idx,
  output logic signed [OUT_W-1:0] out_data
);
  localparam int ACC_W = IN_W + 1 + LUT_W;

  logic                    row_valid;
  logic signed [IN_W:0]    sum_w [HALF];
  logic signed [IN_W:0]    dif_w [HALF];
  logic                    busy_q;
  logic [IDX_W-1:0]        k_q;
  logic [IDX_W-1:0]        cur_k;
  logic                    eng_valid;
  logic                    acc_valid;
  logic [IDX_W-1:0]        acc_k;
  logic signed [ACC_W-1:0] acc;

  dct8_gather #(.IN_W(IN_W)) gather_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .row_valid(row_valid), .sum_o(sum_w), .dif_o(dif_w)
  );

  // One coefficient per clock; a row occupies the engine for N cycles
  assign cur_k     = row_valid ? '0 : k_q;
  assign eng_valid = row_valid | busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      k_q    <= '0;
    end else if (eng_valid) begin
      busy_q <= (cur_k != IDX_W'(N - 1));
      k_q    <= cur_k + 1'b1;
    end
  end

  dct8_da #(.IN_W(IN_W), .ACC_W(ACC_W)) da_i (
    .clk(clk), .rst(rst), .in_valid(eng_valid), .k_i(cur_k),
    .sum_i(sum_w), .dif_i(dif_w),
    .acc_valid(acc_valid), .acc_k(acc_k), .acc_o(acc)
  );

  dct8_round_sat #(.ACC_W(ACC_W), .OUT_W(OUT_W), .FRAC(COEF_FRAC)) rs_i (
    .clk(clk), .rst(rst), .in_valid(acc_valid), .k_i(acc_k), .acc_i(acc),
    .out_valid(out_valid), .out_idx(out_idx), .out_data(out_data)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid); // R1
  AST_BURST_START: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (out_idx == '0)); // R3
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_idx != IDX_W'(N - 1)) |=>
      (out_valid && out_idx == IDX_W'($past(out_idx) + 1'b1))); // R3
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    row_valid |-> !busy_q); // R4
endmodule

// File: tb/dct8_stream_tb_top.sv
module dct8_stream_tb_top;
  localparam int MAXR = 256;
  localparam int WD   = 100000;
  localparam real PI  = 3.14159265358979;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic signed [7:0] in_data = '0;
  logic              o_valid, s_valid;
  logic [2:0]        o_idx, s_idx;
  logic signed [10:0] o_data;
  logic signed [7:0]  s_data;

  dct8_stream #(.IN_W(8), .OUT_W(11)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(o_valid), .out_idx(o_idx), .out_data(o_data));
  dct8_stream #(.IN_W(8), .OUT_W(8)) dut_sat_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(s_valid), .out_idx(s_idx), .out_data(s_data));

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    rows [MAXR][8];
  int    cap  [MAXR];
  string tag  [MAXR];
  int    tmp  [8];
  int    wr = 0, rd = 0, ek = 0;
  int    nchk = 0, nfail = 0;
  int unsigned lf = 32'h1234ACE1;

  function automatic int coef(input int k, input int n);
    if (k == 0) return int'(1024.0 / $sqrt(2.0));
    return int'(1024.0 * $cos(real'((2 * n + 1) * k) * PI / 16.0));
  endfunction

  function automatic int refv(input int r, input int k, input int ow);
    int acc, v, mx;
    acc = 0;
    for (int n = 0; n < 8; n++) acc = acc + rows[r][n] * coef(k, n);
    v  = (acc + 1024) >>> 11;
    mx = (1 << (ow - 1)) - 1;
    if (v > mx) v = mx;
    if (v < -mx - 1) v = -mx - 1;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Output monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (o_valid) begin
        if (rd >= wr) check(1'b0, "R3 output without a row", int'(o_idx), -1);
        else begin
          check(int'(o_idx) == ek, "R3 index order", int'(o_idx), ek);
          check(int'(o_data) == refv(rd, ek, 11), tag[rd], int'(o_data), refv(rd, ek, 11));
          check(s_valid && int'(s_data) == refv(rd, ek, 8), "R8 clamped value",
                int'(s_data), refv(rd, ek, 8));
          if (ek == 0) check(cyc == cap[rd] + 2, "R4 first-coefficient timing", cyc, cap[rd] + 2);
          if (ek == 7) begin ek = 0; rd++; end
          else ek++;
        end
      end else if (ek != 0) begin
        check(1'b0, "R4 burst interrupted", 0, 1);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc >= WD) begin
      nfail++;
      $display("FAIL R4 watchdog expired: actual %0d expected below %0d", cyc, WD);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  // Drive the row in tmp; bit n of gaps inserts an idle cycle before sample n
  task automatic send(input string t, input int gaps);
    rows[wr] = tmp;
    tag[wr]  = t;
    for (int n = 0; n < 8; n++) begin
      if (((gaps >> n) & 1) == 1) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'(tmp[n]);
      if (n == 7) begin
        cap[wr] = cyc + 1;
        wr++;
      end
    end
  endtask

  task automatic idle(input int c);
    for (int i = 0; i < c; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  function automatic int rnd8();
    lf = lf * 32'd1103515245 + 32'd12345;
    return int'((lf >> 16) & 32'hFF) - 128;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(!o_valid && !s_valid, "R1 idle after reset", int'(o_valid), 0);

    // R1: partial row then reset; the partial samples must be forgotten
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'sd100;
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(!o_valid, "R1 no output after reset", int'(o_valid), 0);
    idle(12);
    check(rd == wr, "R1 partial row discarded", rd, wr);
    for (int n = 0; n < 8; n++) tmp[n] = n * 9 - 30;
    send("R1 first row after reset", 0);

    // R5/R7 fixed patterns, back to back (R4)
    for (int n = 0; n < 8; n++) tmp[n] = 0;
    send("R5 zero row", 0);
    for (int n = 0; n < 8; n++) tmp[n] = 127;
    send("R7 all +127", 0);
    for (int n = 0; n < 8; n++) tmp[n] = -128;
    send("R7 all -128", 0);
    for (int n = 0; n < 8; n++) tmp[n] = (n % 2 == 0) ? 127 : -128;
    send("R7 alternating extremes", 0);
    for (int n = 0; n < 8; n++) tmp[n] = (n < 4) ? -128 : 127;
    send("R7 step extremes", 0);
    for (int n = 0; n < 8; n++) tmp[n] = n * 16 - 60;
    send("R5 ramp", 0);

    // R6: mirror-symmetric and antisymmetric rows
    for (int n = 0; n < 4; n++) begin tmp[n] = n * 31 - 50; tmp[7-n] = tmp[n]; end
    send("R6 symmetric row", 0);
    for (int n = 0; n < 4; n++) begin tmp[n] = 90 - n * 45; tmp[7-n] = -tmp[n]; end
    send("R6 antisymmetric row", 0);

    // R5: impulses at each position, both polarities
    for (int p = 0; p < 8; p++) begin
      for (int n = 0; n < 8; n++) tmp[n] = (n == p) ? 127 : 0;
      send("R5 positive impulse", 0);
      for (int n = 0; n < 8; n++) tmp[n] = (n == p) ? -128 : 0;
      send("R5 negative impulse", 0);
    end

    // R2: pseudo-random rows with idle cycles inside and between rows
    for (int r = 0; r < 160; r++) begin
      for (int n = 0; n < 8; n++) tmp[n] = rnd8();
      send("R2 random row", (r % 3 == 0) ? (rnd8() & 8'hFF) : 0);
      if (r % 7 == 0) idle(3);
    end
    idle(20);
    check(rd == wr, "R3 every row produced a burst", rd, wr);
    check(ek == 0, "R3 no partial burst left", ek, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule